// File: doc/BRIEF.md
# Dual Prescaled Phase-Frequency Detector

This block compares two clock-like inputs, a reference and a feedback signal, and produces the UP and DOWN requests that steer a charge pump in a phase-locked loop. Each input first goes through its own prescaler, which can divide by 1, 2 or 4. The rising edges of the two divided signals then set a pair of flip-flops. When both flip-flops are set, they clear together one cycle later, so the output pulse widths track the timing error between the two edges.

A polarity control swaps the UP and DOWN outputs. This lets the block drive an oscillator whose frequency rises with control voltage or one whose frequency falls with it. It also lets either physical input serve as the feedback path. The inputs are sampled by a fast clock `clk_i`, and every output is registered.

A change of divider setting waits until that prescaler is at rest: its count is zero, its divided output is low and its input is low. This prevents a shortened or stretched divided period.

Top module: `dual_prescaled_pfd`

## Requirements
- R1: While `rst_ni` is low, `up_o` and `dn_o` are 0 whatever the inputs do. The polarity register resets to 0 (non-inverted).
- R2: Divider code 2'b00 gives divide-by-1. Every rising edge of the input produces one divided rising edge.
- R3: Divider code 2'b01 gives divide-by-2. The divided output toggles on each input rising edge, so it rises on input rising edges 1, 3, 5 and so on, with a 50% duty cycle.
- R4: Divider code 2'b10 gives divide-by-4. The divided output toggles on every second input rising edge, so it rises on input rising edges 2, 6, 10 and so on, with a 50% duty cycle.
- R5: Divider code 2'b11 is reserved and behaves exactly like divide-by-1.
- R6: With `pol_i` = 0, a divided reference edge that comes d cycles before the divided feedback edge makes `up_o` high for d+1 cycles and `dn_o` high for 1 cycle. A feedback edge that leads gives the mirror case on `dn_o`.
- R7: With `pol_i` = 1, the roles of `up_o` and `dn_o` in R6 are exchanged.
- R8: When both flip-flops are high, both clear on the next clock edge. Coincident edges therefore give exactly one cycle with `up_o` and `dn_o` both high.
- R9: A new divider code is adopted only when that prescaler's count is zero, its divided output is low and its input is low. Until then, the divided output keeps the old ratio.
- R10: An input rise first sampled at clock edge t makes the corresponding output high after edge t+1, for every ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Reference input, synchronous to clk_i |
| fb_i | input | 1 | Feedback input, synchronous to clk_i |
| ref_div_sel_i | input | 2 | Reference divider code (00 ÷1, 01 ÷2, 10 ÷4, 11 ÷1) |
| fb_div_sel_i | input | 2 | Feedback divider code, same encoding |
| pol_i | input | 1 | 0: reference edge drives UP; 1: UP and DOWN swapped |
| up_o | output | 1 | Request to raise control voltage |
| dn_o | output | 1 | Request to lower control voltage |

## Verification
Single pulse pairs are swept over edge offsets of 0 to 5 cycles, in both orders of arrival and with both polarities. The measured high-cycle counts of each output separate a correct lead/lag decision and pulse width from a swapped or stuck polarity and from a wrong clear delay. Pulse trains of 7 and 8 input periods under each of the four divider codes give event counts that distinguish ÷1, ÷2 and ÷4 from one another and confirm that the reserved code acts as ÷1. A divider change issued in the middle of a ÷4 period shows whether the new ratio was adopted too early, and a directly timed edge pins the two-cycle latency.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int DIV_SEL_W = 2;
  localparam int NCH       = 2;          // 0: reference, 1: feedback
  localparam int MAX_HALF  = 2;          // input rises per half period at the largest ratio
  localparam int CNT_W     = $clog2(MAX_HALF);

  typedef enum logic [DIV_SEL_W-1:0] {
    DIV_BY1  = 2'b00,
    DIV_BY2  = 2'b01,
    DIV_BY4  = 2'b10,
    DIV_RSVD = 2'b11
  } div_sel_e;

  function automatic logic is_bypass(div_sel_e s);
    return (s == DIV_BY1) || (s == DIV_RSVD);
  endfunction

  // last count value before the divided output toggles
  function automatic logic [CNT_W-1:0] last_count(div_sel_e s);
    case (s)
      DIV_BY4: return CNT_W'(MAX_HALF - 1);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pfd_prescaler.sv
module pfd_prescaler
  import pfd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_i,
  input  logic [DIV_SEL_W-1:0] sel_i,
  output logic                 div_o
);
  logic             in_q;
  div_sel_e         act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             div_q;
  logic             at_rest;
  logic             in_rise;

  assign at_rest = !div_q && (cnt_q == '0) && !in_i;
  assign in_rise = in_i && !in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= 1'b0;
      act_q <= DIV_BY1;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      in_q <= in_i;
      if (at_rest) act_q <= div_sel_e'(sel_i);
      if (is_bypass(act_q)) begin
        div_q <= in_i;
        cnt_q <= '0;
      end else if (in_rise) begin
        if (cnt_q == last_count(act_q)) begin
          cnt_q <= '0;
          div_q <= !div_q;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign div_o = div_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_div_i,
  input  logic fb_div_i,
  output logic up_o,
  output logic dn_o
);
  logic ref_prev_q, fb_prev_q;
  logic up_q, dn_q;
  logic clr;

  assign clr = up_q && dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_prev_q <= 1'b0;
      fb_prev_q  <= 1'b0;
      up_q       <= 1'b0;
      dn_q       <= 1'b0;
    end else begin
      ref_prev_q <= ref_div_i;
      fb_prev_q  <= fb_div_i;
      // clear has priority; an edge landing in the clear cycle is dropped
      up_q <= clr ? 1'b0 : (up_q || (ref_div_i && !ref_prev_q));
      dn_q <= clr ? 1'b0 : (dn_q || (fb_div_i && !fb_prev_q));
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;
endmodule

// File: rtl/dual_prescaled_pfd.sv
module dual_prescaled_pfd
  import pfd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ref_i,
  input  logic                 fb_i,
  input  logic [DIV_SEL_W-1:0] ref_div_sel_i,
  input  logic [DIV_SEL_W-1:0] fb_div_sel_i,
  input  logic                 pol_i,
  output logic                 up_o,
  output logic                 dn_o
);
  logic [NCH-1:0]                in_w;
  logic [NCH-1:0]                div_w;
  logic [NCH-1:0][DIV_SEL_W-1:0] sel_w;
  logic                          up_raw, dn_raw;
  logic                          pol_q;

  assign in_w  = {fb_i, ref_i};
  assign sel_w = {fb_div_sel_i, ref_div_sel_i};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pfd_prescaler u_div (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (in_w[ch]),
      .sel_i (sel_w[ch]),
      .div_o (div_w[ch])
    );
  end

  pfd_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_div_i(div_w[0]),
    .fb_div_i (div_w[1]),
    .up_o     (up_raw),
    .dn_o     (dn_raw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pol_q <= 1'b0;
    else         pol_q <= pol_i;
  end

  always_comb begin
    up_o = pol_q ? dn_raw : up_raw;
    dn_o = pol_q ? up_raw : dn_raw;
  end
endmodule

// File: rtl/dual_prescaled_pfd_chk.sv
module dual_prescaled_pfd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_div,
  input logic fb_div,
  input logic up_raw,
  input logic dn_raw,
  input logic up_o,
  input logic dn_o
);
  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_QUIET: assert (!up_o && !dn_o); // R1

  AST_CLEAR_AFTER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && dn_o) |=> (!up_o && !dn_o)); // R8

  AST_UP_FROM_REF_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_raw) |-> ($past(ref_div) && !$past(ref_div, 2))); // R6

  AST_DN_FROM_FB_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dn_raw) |-> ($past(fb_div) && !$past(fb_div, 2))); // R6
endmodule

module pfd_prescaler_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_i,
  input logic       in_q,
  input logic       div_q,
  input logic [1:0] act_q
);
  AST_DIV_PACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(div_q) && ($past(act_q) == 2'b01 || $past(act_q) == 2'b10))
      |-> $past(in_i && !in_q)); // R3

  AST_SEL_AT_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> ($past(!div_q) && $past(!in_i))); // R9
endmodule

bind dual_prescaled_pfd dual_prescaled_pfd_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ref_div(div_w[0]),
  .fb_div (div_w[1]),
  .up_raw (up_raw),
  .dn_raw (dn_raw),
  .up_o   (up_o),
  .dn_o   (dn_o)
);

bind pfd_prescaler pfd_prescaler_chk u_div_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .in_i  (in_i),
  .in_q  (in_q),
  .div_q (div_q),
  .act_q (act_q)
);

// File: tb/dual_prescaled_pfd_test.sv
module dual_prescaled_pfd_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       ref_i = 1'b0, fb_i = 1'b0;
  logic [1:0] ref_sel = 2'b00, fb_sel = 2'b00;
  logic       pol_i = 1'b0;
  logic       up_o, dn_o;

  int n_chk = 0, n_bad = 0;
  int up_n, dn_n, both_n, up_r;

  always #(CLK_PERIOD / 2) clk_i = !clk_i;

  dual_prescaled_pfd uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .fb_i(fb_i),
    .ref_div_sel_i(ref_sel), .fb_div_sel_i(fb_sel), .pol_i(pol_i),
    .up_o(up_o), .dn_o(dn_o)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic wave(int c, int n, int p, int h);
    return (c >= 0) && (c < n * p) && ((c % p) < h);
  endfunction

  task automatic do_reset(logic [1:0] rs, logic [1:0] fs, logic p);
    @(negedge clk_i);
    ref_i = 1'b0; fb_i = 1'b0;
    ref_sel = rs; fb_sel = fs; pol_i = p;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  // sample outputs, then drive the next input value, at each falling edge
  task automatic run(int n, int p, int h, int ref_off, int fb_off, int tail);
    int   last;
    logic up_prev;
    last = n * p + ((ref_off > fb_off) ? ref_off : fb_off) + tail;
    up_n = 0; dn_n = 0; both_n = 0; up_r = 0; up_prev = up_o;
    for (int c = 0; c < last; c++) begin
      @(negedge clk_i);
      up_n   += int'(up_o);
      dn_n   += int'(dn_o);
      both_n += int'(up_o && dn_o);
      if (up_o && !up_prev) up_r++;
      up_prev = up_o;
      ref_i = wave(c - ref_off, n, p, h);
      fb_i  = wave(c - fb_off, n, p, h);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    summary();
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;

    // R1: outputs quiet while in reset even with active inputs
    repeat (2) @(negedge clk_i);
    ref_i = 1'b1; pol_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1 up in reset", int'(up_o), 0);
    check("R1 dn in reset", int'(dn_o), 0);
    do_reset(2'b00, 2'b00, 1'b0);
    check("R1 up after reset", int'(up_o), 0);
    check("R1 dn after reset", int'(dn_o), 0);

    // R10: latency from a sampled input rise to the output
    ref_i = 1'b1;
    @(negedge clk_i);
    check("R10 up one edge after rise", int'(up_o), 0);
    @(negedge clk_i);
    check("R10 up two edges after rise", int'(up_o), 1);
    fb_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R10 cleared after fb", int'(up_o || dn_o), 0);
    ref_i = 1'b0; fb_i = 1'b0;
    repeat (3) @(negedge clk_i);

    // R6/R7/R8: offset sweep, both arrival orders, both polarities
    for (int pol = 0; pol < 2; pol++)
      for (int lead_fb = 0; lead_fb < 2; lead_fb++)
        for (int d = 0; d < 6; d++) begin
          int exp_up, exp_dn, t;
          do_reset(2'b00, 2'b00, pol[0]);
          run(1, 20, 8, lead_fb ? d : 0, lead_fb ? 0 : d, 10);
          exp_up = lead_fb ? 1 : d + 1;
          exp_dn = lead_fb ? d + 1 : 1;
          if (pol != 0) begin t = exp_up; exp_up = exp_dn; exp_dn = t; end
          check(pol ? "R7 up width" : "R6 up width", up_n, exp_up);
          check(pol ? "R7 dn width" : "R6 dn width", dn_n, exp_dn);
          check("R8 overlap cycles", both_n, 1);
        end

    // R2-R5: ratio sweep with trains of 7 and 8 periods
    for (int sel = 0; sel < 4; sel++)
      for (int n = 7; n <= 8; n++) begin
        int e;
        string tag;
        case (sel)
          1: begin e = (n + 1) / 2; tag = "R3 div2"; end
          2: begin e = (n + 2) / 4; tag = "R4 div4"; end
          3: begin e = n;           tag = "R5 reserved"; end
          default: begin e = n;     tag = "R2 div1"; end
        endcase
        do_reset(sel[1:0], sel[1:0], 1'b0);
        run(n, 6, 3, 0, 2, 12);
        check({tag, " events"}, up_r, e);
        check({tag, " up cycles"}, up_n, 3 * e);
        check({tag, " dn cycles"}, dn_n, e);
      end

    // R9: ratio change mid-period is deferred until the divider is at rest
    do_reset(2'b10, 2'b10, 1'b0);
    run(2, 6, 3, 0, 2, 12);
    check("R9 div4 first pair", up_r, 1);
    ref_sel = 2'b00; fb_sel = 2'b00;
    run(2, 6, 3, 0, 2, 12);
    check("R9 old ratio kept", up_r, 0);
    run(3, 6, 3, 0, 2, 12);
    check("R9 new ratio adopted", up_r, 3);
    check("R9 dn after adopt", dn_n, 3);

    summary();
    $finish;
  end
endmodule